// File: doc/BRIEF.md
# Dynamic Capacity Extent Table Manager

This block holds a small, fixed-size table of memory extents that a host has accepted. Each extent is a start address and a length, plus a valid bit. A command arrives as an opcode and an entry count, followed by that many entries on a one-entry-per-cycle stream. The block accepts new extents with the add command. It removes extents with the release command. When a release removes only a middle or end part of a stored extent, the stored extent is split into remnant extents.

Every entry is compared against all table slots in parallel, so one entry is applied per clock cycle. Entries are handled in list order. The first error stops the list: entries already applied stay applied, and the rest of the list is accepted and discarded. The live extent count is always visible. A one-cycle done pulse carries one status per command.

Top module: `dc_extent_mgr`

## Requirements
- R1: After reset, extent_count is 0, busy and done are low, and the table holds no extent, so a release of any range returns status 8'h08.
- R2: Opcode 16'h4802 selects add and 16'h4803 selects release. Any other opcode returns 8'h02. Its entries are drained and the table is left unchanged.
- R3: A command with a count of zero ends with done one cycle after cmd_valid. For add the status is 8'h00 and nothing changes. For release the status is 8'h02.
- R4: An add entry that overlaps any stored extent in any way returns 8'h08. This covers an entry inside a stored extent, one crossing either end, and one covering a stored extent.
- R5: An add entry that overlaps nothing is stored in a free slot, and extent_count rises by one. extent_count always equals the number of valid slots.
- R6: A release entry equal to a stored extent removes it, and extent_count falls by one.
- R7: A release entry strictly inside a stored extent leaves the part before it and the part after it as separate extents, and extent_count rises by one. When only one side remains, that side alone is kept and the count is unchanged.
- R8: A release entry that overlaps a stored extent without lying wholly inside it returns 8'h1E. One that overlaps no stored extent returns 8'h08.
- R9: An add, or a split that needs a second slot, returns 8'h0B when no slot is free, and the table is left unchanged.
- R10: Entries are processed in list order. Entries applied before the first error stay applied. Entries after it have no effect, and the status is that of the first error.
- R11: busy is high from the cycle after cmd_valid until done. done is a one-cycle pulse in the cycle after the last entry is taken, and status is valid while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Starts a command (taken only when not busy) |
| cmd_opcode | input | OP_W | Command opcode |
| cmd_count | input | LIST_W | Number of entries that follow |
| ent_valid | input | 1 | An entry is present on this cycle |
| ent_start | input | AW | Entry start address |
| ent_len | input | AW | Entry length (nonzero) |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| status | output | 8 | Command status, valid with done |
| extent_count | output | $clog2(SLOTS+1) | Number of stored extents |

## Verification
The add path is tried with entries that are disjoint, nested, straddling either end and enclosing, which separates the overlap test from a plain start-address compare. Release is tried with exact matches, interior, head-only and tail-only targets, straddling targets and unknown ranges, which separates the remnant arithmetic and the two distinct error codes. Full-table and mid-list-error lists show whether a failing entry leaves earlier work intact and later entries unapplied. Random add/release mixes, where releases are often drawn from stored extents, are then compared against a bench model of the extent set.

// File: rtl/dc_extent_pkg.sv
package dc_extent_pkg;

    typedef enum logic [7:0] {
        ST_OK        = 8'h00,
        ST_BAD_INPUT = 8'h02,
        ST_BAD_ADDR  = 8'h08,
        ST_NO_ROOM   = 8'h0B,
        ST_BAD_LIST  = 8'h1E
    } status_e;

    typedef enum logic [1:0] {
        K_ADD,
        K_REL,
        K_BAD
    } kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RUN,
        S_FIN
    } state_e;

    localparam logic [15:0] OPC_ADD = 16'h4802;
    localparam logic [15:0] OPC_REL = 16'h4803;

    function automatic kind_e decode_op(input logic [15:0] op);
        if (op == OPC_ADD)      return K_ADD;
        else if (op == OPC_REL) return K_REL;
        else                    return K_BAD;
    endfunction

endpackage

// File: rtl/ext_match.sv
module ext_match #(
    parameter int SLOTS = 8,
    parameter int AW    = 16
) (
    input  logic [SLOTS-1:0]         slot_v,
    input  logic [SLOTS-1:0][AW-1:0] slot_s,
    input  logic [SLOTS-1:0][AW-1:0] slot_l,
    input  logic [AW-1:0]            q_start,
    input  logic [AW-1:0]            q_len,
    output logic [SLOTS-1:0]         overlap,
    output logic [SLOTS-1:0]         contain
);
    logic [AW:0] q_lo;
    logic [AW:0] q_hi;

    assign q_lo = {1'b0, q_start};
    assign q_hi = {1'b0, q_start} + {1'b0, q_len};

    for (genvar k = 0; k < SLOTS; k++) begin : g_cmp
        logic [AW:0] e_lo;
        logic [AW:0] e_hi;
        assign e_lo = {1'b0, slot_s[k]};
        assign e_hi = {1'b0, slot_s[k]} + {1'b0, slot_l[k]};
        assign overlap[k] = slot_v[k] && (q_lo < e_hi) && (q_hi > e_lo);
        assign contain[k] = slot_v[k] && (q_lo >= e_lo) && (q_hi <= e_hi);
    end

endmodule

// File: rtl/ext_alloc.sv
module ext_alloc #(
    parameter int SLOTS = 8,
    parameter int IW    = 3
) (
    input  logic [SLOTS-1:0] slot_v,
    output logic             found,
    output logic [IW-1:0]    idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = SLOTS - 1; k >= 0; k--) begin
            if (!slot_v[k]) begin
                found = 1'b1;
                idx   = IW'(k);
            end
        end
    end

endmodule

// File: rtl/dc_extent_mgr.sv
module dc_extent_mgr
    import dc_extent_pkg::*;
#(
    parameter int AW     = 16,
    parameter int SLOTS  = 8,
    parameter int LIST_W = 32,
    parameter int OP_W   = 16,
    localparam int CW    = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [OP_W-1:0]   cmd_opcode,
    input  logic [LIST_W-1:0] cmd_count,
    input  logic              ent_valid,
    input  logic [AW-1:0]     ent_start,
    input  logic [AW-1:0]     ent_len,
    output logic              busy,
    output logic              done,
    output logic [7:0]        status,
    output logic [CW-1:0]     extent_count
);
    localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [CW-1:0] FULL = CW'(SLOTS);

    state_e state;
    kind_e  kind;
    logic [LIST_W-1:0] remain;
    logic              err;
    status_e           status_q;
    logic [CW-1:0]     cnt_q;

    logic [SLOTS-1:0]         tab_v;
    logic [SLOTS-1:0][AW-1:0] tab_s;
    logic [SLOTS-1:0][AW-1:0] tab_l;

    logic [SLOTS-1:0] ovl, con;
    logic             free_ok;
    logic [IW-1:0]    free_idx;

    ext_match #(.SLOTS(SLOTS), .AW(AW)) i_match (
        .slot_v (tab_v),
        .slot_s (tab_s),
        .slot_l (tab_l),
        .q_start(ent_start),
        .q_len  (ent_len),
        .overlap(ovl),
        .contain(con)
    );

    ext_alloc #(.SLOTS(SLOTS), .IW(IW)) i_alloc (
        .slot_v(tab_v),
        .found (free_ok),
        .idx   (free_idx)
    );

    // Index of the stored extent that wholly holds the entry
    logic [IW-1:0] con_idx;
    always_comb begin
        con_idx = '0;
        for (int k = 0; k < SLOTS; k++) begin
            if (con[k]) con_idx = IW'(k);
        end
    end

    logic [AW-1:0] hit_s;
    logic [AW:0]   hit_end, q_end, tail_w;
    logic [AW-1:0] head, tail;

    assign hit_s   = tab_s[con_idx];
    assign hit_end = {1'b0, hit_s} + {1'b0, tab_l[con_idx]};
    assign q_end   = {1'b0, ent_start} + {1'b0, ent_len};
    assign head    = ent_start - hit_s;
    assign tail_w  = hit_end - q_end;
    assign tail    = tail_w[AW-1:0];

    // Per-entry decision
    status_e       res;
    logic          wa_en, wa_v, wb_en, cnt_up, cnt_dn;
    logic [AW-1:0] wa_s, wa_l, wb_s, wb_l;

    always_comb begin
        res    = ST_OK;
        wa_en  = 1'b0;
        wa_v   = 1'b0;
        wa_s   = '0;
        wa_l   = '0;
        wb_en  = 1'b0;
        wb_s   = '0;
        wb_l   = '0;
        cnt_up = 1'b0;
        cnt_dn = 1'b0;
        unique case (kind)
            K_ADD: begin
                if (|ovl) begin
                    res = ST_BAD_ADDR;
                end else if (!free_ok) begin
                    res = ST_NO_ROOM;
                end else begin
                    wb_en  = 1'b1;
                    wb_s   = ent_start;
                    wb_l   = ent_len;
                    cnt_up = 1'b1;
                end
            end
            K_REL: begin
                if (|con) begin
                    if (head != '0 && tail != '0) begin
                        if (!free_ok) begin
                            res = ST_NO_ROOM;
                        end else begin
                            wa_en  = 1'b1;
                            wa_v   = 1'b1;
                            wa_s   = hit_s;
                            wa_l   = head;
                            wb_en  = 1'b1;
                            wb_s   = q_end[AW-1:0];
                            wb_l   = tail;
                            cnt_up = 1'b1;
                        end
                    end else if (head != '0) begin
                        wa_en = 1'b1;
                        wa_v  = 1'b1;
                        wa_s  = hit_s;
                        wa_l  = head;
                    end else if (tail != '0) begin
                        wa_en = 1'b1;
                        wa_v  = 1'b1;
                        wa_s  = q_end[AW-1:0];
                        wa_l  = tail;
                    end else begin
                        wa_en  = 1'b1;
                        wa_v   = 1'b0;
                        cnt_dn = 1'b1;
                    end
                end else if (|ovl) begin
                    res = ST_BAD_LIST;
                end else begin
                    res = ST_BAD_ADDR;
                end
            end
            default: res = ST_BAD_INPUT;
        endcase
    end

    logic take, apply;
    assign take  = (state == S_RUN) && ent_valid;
    assign apply = take && !err;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            kind     <= K_BAD;
            remain   <= '0;
            err      <= 1'b0;
            status_q <= ST_OK;
            cnt_q    <= '0;
            tab_v    <= '0;
            tab_s    <= '0;
            tab_l    <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (cmd_valid) begin
                        kind   <= decode_op(16'(cmd_opcode));
                        remain <= cmd_count;
                        if (cmd_count == '0) begin
                            status_q <= (decode_op(16'(cmd_opcode)) == K_ADD) ? ST_OK : ST_BAD_INPUT;
                            state    <= S_FIN;
                        end else if (decode_op(16'(cmd_opcode)) == K_BAD) begin
                            status_q <= ST_BAD_INPUT;
                            err      <= 1'b1;
                            state    <= S_RUN;
                        end else begin
                            status_q <= ST_OK;
                            err      <= 1'b0;
                            state    <= S_RUN;
                        end
                    end
                end
                S_RUN: begin
                    if (take) begin
                        remain <= remain - 1'b1;
                        if (remain == LIST_W'(1)) state <= S_FIN;
                    end
                    if (apply) begin
                        if (wa_en) begin
                            tab_v[con_idx] <= wa_v;
                            tab_s[con_idx] <= wa_s;
                            tab_l[con_idx] <= wa_l;
                        end
                        if (wb_en) begin
                            tab_v[free_idx] <= 1'b1;
                            tab_s[free_idx] <= wb_s;
                            tab_l[free_idx] <= wb_l;
                        end
                        if (cnt_up)      cnt_q <= cnt_q + 1'b1;
                        else if (cnt_dn) cnt_q <= cnt_q - 1'b1;
                        if (res != ST_OK) begin
                            err      <= 1'b1;
                            status_q <= res;
                        end
                    end
                end
                default: begin
                    err   <= 1'b0;
                    state <= S_IDLE;
                end
            endcase
        end
    end

    assign busy         = (state != S_IDLE);
    assign done         = (state == S_FIN);
    assign status       = status_q;
    assign extent_count = cnt_q;

    // R5: count tracks occupied slots and never exceeds the table
    p_count_matches_r5: assert property (@(posedge clk) disable iff (rst)
        ($countones(tab_v) == int'(cnt_q)) && (cnt_q <= FULL));

    // R6: a stored extent set never holds an entry in two places
    p_single_home_r6: assert property (@(posedge clk) disable iff (rst)
        take |-> $onehot0(con));

    // R9: the allocator only ever hands out an unused slot
    p_free_slot_r9: assert property (@(posedge clk) disable iff (rst)
        (take && free_ok) |-> !tab_v[free_idx]);

    // R10: once an error is latched, the rest of the list changes nothing
    p_err_freezes_r10: assert property (@(posedge clk) disable iff (rst)
        (state == S_RUN && err) |=> ($stable(tab_v) && $stable(cnt_q)));

    // R10: the count moves only when an entry was taken
    p_count_moves_r10: assert property (@(posedge clk) disable iff (rst)
        (!take) |=> $stable(cnt_q));

    // R11: done is a single-cycle pulse followed by idle
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

endmodule

// File: tb/test_dc_extent_mgr.sv
module test_dc_extent_mgr;
    localparam int SLOTS = 8;
    localparam int AW    = 16;
    localparam logic [15:0] OP_ADD = 16'h4802;
    localparam logic [15:0] OP_REL = 16'h4803;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_opcode = '0;
    logic [31:0] cmd_count = '0;
    logic        ent_valid = 1'b0;
    logic [15:0] ent_start = '0;
    logic [15:0] ent_len = '0;
    logic        busy, done;
    logic [7:0]  status;
    logic [3:0]  extent_count;

    always #10 clk = ~clk;

    dc_extent_mgr #(.AW(AW), .SLOTS(SLOTS)) i_dc_extent_mgr (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
        .cmd_count(cmd_count), .ent_valid(ent_valid), .ent_start(ent_start),
        .ent_len(ent_len), .busy(busy), .done(done), .status(status),
        .extent_count(extent_count)
    );

    int checks = 0;
    int errors = 0;

    // Bench model of the extent set
    int m_s [SLOTS];
    int m_l [SLOTS];
    bit m_v [SLOTS];
    int m_cnt = 0;
    int q_s [8];
    int q_l [8];

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit m_ovl(input int k, input int d, input int l);
        return m_v[k] && (d < m_s[k] + m_l[k]) && (d + l > m_s[k]);
    endfunction

    task automatic m_put(input int d, input int l);
        for (int k = 0; k < SLOTS; k++) begin
            if (!m_v[k]) begin
                m_v[k] = 1; m_s[k] = d; m_l[k] = l;
                return;
            end
        end
    endtask

    task automatic model_cmd(input logic [15:0] op, input int n, output int st);
        st = 0;
        if (op != OP_ADD && op != OP_REL) begin st = 8'h02; return; end
        if (n == 0) begin st = (op == OP_ADD) ? 0 : 8'h02; return; end
        for (int i = 0; i < n; i++) begin
            int d, l, hit, any;
            d = q_s[i]; l = q_l[i]; hit = -1; any = 0;
            for (int k = 0; k < SLOTS; k++) begin
                if (m_ovl(k, d, l)) any = 1;
                if (m_v[k] && d >= m_s[k] && d + l <= m_s[k] + m_l[k]) hit = k;
            end
            if (op == OP_ADD) begin
                if (any) begin st = 8'h08; return; end
                if (m_cnt == SLOTS) begin st = 8'h0B; return; end
                m_put(d, l); m_cnt++;
            end else begin
                if (hit < 0) begin st = any ? 8'h1E : 8'h08; return; end
                begin
                    int hs, hl, h, t;
                    hs = m_s[hit]; hl = m_l[hit];
                    h = d - hs; t = hs + hl - (d + l);
                    if (h > 0 && t > 0 && m_cnt == SLOTS) begin st = 8'h0B; return; end
                    m_v[hit] = 0; m_cnt--;
                    if (h > 0) begin m_put(hs, h); m_cnt++; end
                    if (t > 0) begin m_put(d + l, t); m_cnt++; end
                end
            end
        end
    endtask

    task automatic do_cmd(input string req, input logic [15:0] op, input int n);
        int exp_st;
        model_cmd(op, n, exp_st);
        @(negedge clk);
        cmd_valid = 1; cmd_opcode = op; cmd_count = n;
        @(negedge clk);
        cmd_valid = 0;
        if (n > 0) begin
            chk({req, " R11 busy"}, int'(busy), 1);
            for (int i = 0; i < n; i++) begin
                ent_valid = 1; ent_start = q_s[i][15:0]; ent_len = q_l[i][15:0];
                @(negedge clk);
            end
            ent_valid = 0;
        end
        chk({req, " R11 done"}, int'(done), 1);
        chk({req, " status"}, int'(status), exp_st);
        chk({req, " count"}, int'(extent_count), m_cnt);
        @(negedge clk);
        chk({req, " R11 done clears"}, int'(done), 0);
    endtask

    task automatic one(input string req, input logic [15:0] op, input int d, input int l);
        q_s[0] = d; q_l[0] = l;
        do_cmd(req, op, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < SLOTS; k++) m_v[k] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 count", int'(extent_count), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);

        do_cmd("R3 add zero", OP_ADD, 0);
        do_cmd("R3 release zero", OP_REL, 0);
        q_s[0] = 'h10; q_l[0] = 'h10; q_s[1] = 'h40; q_l[1] = 'h10;
        do_cmd("R2 bad opcode", 16'h4801, 2);
        one("R1 empty release", OP_REL, 'h10, 'h10);

        one("R5 add", OP_ADD, 'h100, 'h40);
        one("R4 inside", OP_ADD, 'h110, 'h10);
        one("R4 low end", OP_ADD, 'h0F0, 'h20);
        one("R4 high end", OP_ADD, 'h130, 'h20);
        one("R4 cover", OP_ADD, 'h0F0, 'h80);
        one("R7 interior", OP_REL, 'h110, 'h10);
        one("R6 head remnant", OP_REL, 'h100, 'h10);
        one("R6 tail remnant", OP_REL, 'h120, 'h20);

        one("R5 add2", OP_ADD, 'h200, 'h40);
        one("R7 head cut", OP_REL, 'h200, 'h10);
        one("R7 tail cut", OP_REL, 'h230, 'h10);
        one("R8 straddle", OP_REL, 'h220, 'h20);
        one("R8 unknown", OP_REL, 'h300, 'h10);

        q_s[0] = 'h400; q_l[0] = 'h10;
        q_s[1] = 'h400; q_l[1] = 'h10;
        q_s[2] = 'h420; q_l[2] = 'h10;
        do_cmd("R10 mid error", OP_ADD, 3);
        one("R10 skipped entry absent", OP_REL, 'h420, 'h10);

        for (int i = 0; i < 6; i++) begin q_s[i] = 'h500 + i * 'h40; q_l[i] = 'h30; end
        do_cmd("R5 fill", OP_ADD, 6);
        one("R9 add full", OP_ADD, 'h800, 'h10);
        one("R9 split full", OP_REL, 'h510, 'h10);
        one("R6 exact", OP_REL, 'h500, 'h30);

        for (int r = 0; r < 300; r++) begin
            int n;
            logic [15:0] op;
            n = (($urandom % 10) == 0) ? 0 : 1 + ($urandom % 3);
            op = ($urandom % 2) ? OP_ADD : OP_REL;
            for (int i = 0; i < n; i++) begin
                if (op == OP_REL && m_cnt > 0 && ($urandom % 3) != 0) begin
                    int k, u, off, w;
                    k = $urandom % SLOTS;
                    while (!m_v[k]) k = (k + 1) % SLOTS;
                    u = m_l[k] / 16;
                    off = $urandom % u;
                    w = 1 + ($urandom % (u - off));
                    q_s[i] = m_s[k] + off * 16; q_l[i] = w * 16;
                end else begin
                    q_s[i] = ($urandom % 24) * 16;
                    q_l[i] = (1 + ($urandom % 4)) * 16;
                end
            end
            do_cmd(op == OP_ADD ? "R5 random add" : "R7 random release", op, n);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule